// File: doc/BRIEF.md
# Timer Clock Prescaler with Cross-Domain Event Flag

This block produces the count-enable strobe for a timer. The timer source clock reaches it already selected. The block reports which source the mode selects imply: the system I/O clock, a crystal oscillator, or an external clock on the oscillator input. A 10-bit prescaler runs freely on the timer clock. A 3-bit clock-select field picks a tap, and the block emits a one-cycle count-enable pulse at that division ratio. The field can also stop counting entirely or pass every timer edge through.

Software can reset the prescaler from the processor domain, so that the next tick comes at a predictable time. The request crosses to the timer domain as a toggle. A raw timer event, such as a compare match or an overflow, crosses the other way as a toggle. It sets a processor-side interrupt flag with a fixed latency, and software clears the flag by writing one. Each domain has its own synchronous active-high reset.

Top module: `tmr_prescale_async`

## Requirements
- R1: `src_sel` reports the timer source. It is 0 (system I/O clock) when `async_en` is 0, whatever `ext_clk_en` is. It is 1 (crystal oscillator) when `async_en` is 1 and `ext_clk_en` is 0. It is 2 (external clock) when both are 1.
- R2: With `clk_sel` = 000 (stop), `count_en` stays 0. With `clk_sel` = 001 (undivided), `count_en` stays 1.
- R3: The prescaler advances by one on every timer edge and wraps modulo 1024. For the divided settings, `count_en` is high exactly while all prescaler bits below the selected tap are ones. The encodings are 010 = /8, 011 = /32, 100 = /64, 101 = /128, 110 = /256 and 111 = /1024. With N as the ratio, `count_en` is high in the cycle where the prescaler value mod N equals N-1.
- R4: In a divided setting with `clk_sel` steady, `count_en` is never high for two timer cycles in a row.
- R5: A `psc_clr_req` sampled high at a processor edge clears the prescaler to 0 on the third timer edge after that processor edge. The first enable after the clear therefore comes N-1 timer edges later.
- R6: A `tmr_event` sampled high at a timer edge sets `irq_flag` on the third processor edge after that timer edge, and not before.
- R7: `irq_flag` holds until a processor edge samples `flag_clr` high, which clears it. If a set and a clear arrive at the same edge, the set wins.
- R8: Under reset, `irq_flag` is 0 and the prescaler is 0. After the timer reset is released, the k-th timer edge leaves the prescaler at k, so with /8 the first enable follows the seventh edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| cpu_clk | input | 1 | Processor clock |
| cpu_rst | input | 1 | Synchronous active-high reset, processor domain |
| tmr_clk | input | 1 | Timer source clock, already selected |
| tmr_rst | input | 1 | Synchronous active-high reset, timer domain |
| async_en | input | 1 | Asynchronous timer clocking mode |
| ext_clk_en | input | 1 | External clock on the oscillator input (with async_en) |
| clk_sel | input | 3 | Division setting |
| psc_clr_req | input | 1 | Prescaler reset request, processor domain |
| tmr_event | input | 1 | Raw timer event, timer domain |
| flag_clr | input | 1 | Write-one-to-clear for the interrupt flag |
| src_sel | output | 2 | Timer source indication |
| count_en | output | 1 | Timer count-enable strobe, timer domain |
| irq_flag | output | 1 | Interrupt flag, processor domain |

## Verification
The bench clears the prescaler at a known instant for every clock-select value. It then compares `count_en` on each timer edge for over two full periods against an arithmetic model. A design with a wrong tap, such as /16 in place of /32, or with an off-by-one in the clear latency, shows a shifted or wrongly spaced pulse.

The two clocks are chosen so that no timer edge ever coincides with a processor edge. This makes the three-edge latency of the event flag exact, so one flop too many or too few in the synchronizer shows up as an early or late flag. A set arriving together with a clear tests the set-over-clear priority, which would lose an event if it were inverted. The reset-release count checks that the prescaler really starts from zero.

// File: rtl/tmr_prescale_async.sv
module tmr_prescale_async #(
  parameter int PSC_W = 10
) (
  input  logic       cpu_clk,
  input  logic       cpu_rst,
  input  logic       tmr_clk,
  input  logic       tmr_rst,
  input  logic       async_en,
  input  logic       ext_clk_en,
  input  logic [2:0] clk_sel,
  input  logic       psc_clr_req,
  input  logic       tmr_event,
  input  logic       flag_clr,
  output logic [1:0] src_sel,
  output logic       count_en,
  output logic       irq_flag
);

  function automatic logic [PSC_W-1:0] tap_mask(input logic [2:0] s);
    int n;
    case (s)
      3'd2:    n = 3;
      3'd3:    n = 5;
      3'd4:    n = 6;
      3'd5:    n = 7;
      3'd6:    n = 8;
      default: n = PSC_W;
    endcase
    return PSC_W'((64'd1 << n) - 64'd1);
  endfunction

  assign src_sel = !async_en ? 2'd0 : (ext_clk_en ? 2'd2 : 2'd1);

  // prescaler reset request: toggle into the timer domain
  logic clr_tgl;
  logic [2:0] clr_sync;
  logic clr_hit;

  always_ff @(posedge cpu_clk)
    if (cpu_rst) clr_tgl <= 1'b0;
    else         clr_tgl <= clr_tgl ^ psc_clr_req;

  always_ff @(posedge tmr_clk)
    if (tmr_rst) clr_sync <= '0;
    else         clr_sync <= {clr_sync[1:0], clr_tgl};

  assign clr_hit = clr_sync[2] ^ clr_sync[1];

  logic [PSC_W-1:0] psc;
  logic [PSC_W-1:0] mask;

  always_ff @(posedge tmr_clk)
    if (tmr_rst || clr_hit) psc <= '0;
    else                    psc <= psc + 1'b1;

  assign mask     = tap_mask(clk_sel);
  assign count_en = (clk_sel == 3'd1) || (clk_sel >= 3'd2 && (psc & mask) == mask);

  // timer event: toggle into the processor domain
  logic ev_tgl;
  logic [2:0] ev_sync;
  logic ev_hit;

  always_ff @(posedge tmr_clk)
    if (tmr_rst) ev_tgl <= 1'b0;
    else         ev_tgl <= ev_tgl ^ tmr_event;

  always_ff @(posedge cpu_clk)
    if (cpu_rst) ev_sync <= '0;
    else         ev_sync <= {ev_sync[1:0], ev_tgl};

  assign ev_hit = ev_sync[2] ^ ev_sync[1];

  always_ff @(posedge cpu_clk)
    if (cpu_rst)       irq_flag <= 1'b0;
    else if (ev_hit)   irq_flag <= 1'b1;
    else if (flag_clr) irq_flag <= 1'b0;

  p_step_r3: assert property (@(posedge tmr_clk) disable iff (tmr_rst)
    !clr_hit |=> psc == PSC_W'($past(psc) + 1'b1));

  p_single_pulse_r4: assert property (@(posedge tmr_clk) disable iff (tmr_rst)
    (count_en && clk_sel >= 3'd2) |=> (!count_en || !$stable(clk_sel)));

  p_clear_r5: assert property (@(posedge tmr_clk) disable iff (tmr_rst)
    clr_hit |=> psc == '0);

  p_set_r6: assert property (@(posedge cpu_clk) disable iff (cpu_rst)
    ev_hit |=> irq_flag);

  p_hold_r7: assert property (@(posedge cpu_clk) disable iff (cpu_rst)
    (irq_flag && !flag_clr) |=> irq_flag);

  p_wclr_r7: assert property (@(posedge cpu_clk) disable iff (cpu_rst)
    (flag_clr && !ev_hit) |=> !irq_flag);

endmodule

// File: tb/tmr_prescale_async_test.sv
`timescale 1ns/100ps
module tmr_prescale_async_test;
  logic cpu_clk = 0, tmr_clk = 0;
  logic cpu_rst = 1, tmr_rst = 1;
  logic async_en = 0, ext_clk_en = 0;
  logic [2:0] clk_sel = 3'd2;
  logic psc_clr_req = 0, tmr_event = 0, flag_clr = 0;
  logic [1:0] src_sel;
  logic count_en, irq_flag;
  int n_chk = 0, n_fail = 0;

  always #5  cpu_clk = ~cpu_clk;
  always #16 tmr_clk = ~tmr_clk;

  tmr_prescale_async uut (.*);

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int ratio(input int s);
    case (s)
      2: return 8;    3: return 32;  4: return 64;
      5: return 128;  6: return 256; default: return 1024;
    endcase
  endfunction

  function automatic bit exp_en(input int s, input int k);
    if (s == 0) return 0;
    if (s == 1) return 1;
    return (k % ratio(s)) == ratio(s) - 1;
  endfunction

  // R5: clear, then prescaler equals k after k further timer edges
  task automatic sweep(input int s);
    int len;
    clk_sel = 3'(s);
    len = (s < 2) ? 40 : 2 * ratio(s) + 8;
    @(posedge cpu_clk); #1 psc_clr_req = 1;
    @(posedge cpu_clk);
    fork #1 psc_clr_req = 0; join_none
    repeat (3) @(posedge tmr_clk);
    for (int k = 0; k < len; k++) begin
      if (k > 0) @(posedge tmr_clk);
      #2;
      if (s < 2) chk(count_en == exp_en(s, k), "R2", count_en, exp_en(s, k));
      else       chk(count_en == exp_en(s, k), "R3/R5", count_en, exp_en(s, k));
    end
  endtask

  task automatic fire_event;
    @(posedge tmr_clk); #1 tmr_event = 1;
    @(posedge tmr_clk);
    fork #1 tmr_event = 0; join_none
  endtask

  initial begin : wd
    #3000000;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk + 1, n_fail + 1);
    $finish;
  end

  initial begin
    repeat (10) @(posedge cpu_clk);
    #2 chk(irq_flag == 0, "R8", irq_flag, 0);
    #1 cpu_rst = 0;
    @(posedge tmr_clk); #1 tmr_rst = 0;
    // R8: after release, the 7th timer edge brings the first /8 enable
    repeat (6) @(posedge tmr_clk);
    #2 chk(count_en == 0, "R8", count_en, 0);
    @(posedge tmr_clk); #2 chk(count_en == 1, "R8", count_en, 1);

    // R1: source indication for all mode combinations
    for (int m = 0; m < 4; m++) begin
      async_en = m[1]; ext_clk_en = m[0];
      #1 chk(src_sel == (m < 2 ? 0 : (m == 2 ? 1 : 2)), "R1", src_sel, (m < 2 ? 0 : (m == 2 ? 1 : 2)));
    end

    for (int s = 0; s < 8; s++) sweep(s);

    // R4: steady /8 setting, enables never back to back
    clk_sel = 3'd2;
    begin
      logic prev = 0;
      for (int k = 0; k < 64; k++) begin
        @(posedge tmr_clk); #2;
        chk(!(prev && count_en), "R4", count_en, 0);
        prev = count_en;
      end
    end

    // R6: exact latency of three processor edges
    fire_event;
    repeat (2) @(posedge cpu_clk);
    #2 chk(irq_flag == 0, "R6", irq_flag, 0);
    @(posedge cpu_clk); #2 chk(irq_flag == 1, "R6", irq_flag, 1);

    // R7: flag holds, then write-one clears
    repeat (5) @(posedge cpu_clk);
    #2 chk(irq_flag == 1, "R7", irq_flag, 1);
    @(posedge cpu_clk); #1 flag_clr = 1;
    @(posedge cpu_clk); #1 flag_clr = 0;
    #1 chk(irq_flag == 0, "R7", irq_flag, 0);

    // R7: set and clear at the same edge, set wins
    fire_event;
    repeat (2) @(posedge cpu_clk);
    #1 flag_clr = 1;
    @(posedge cpu_clk); #1 flag_clr = 0;
    #1 chk(irq_flag == 1, "R7", irq_flag, 1);
    @(posedge cpu_clk); #1 flag_clr = 1;
    @(posedge cpu_clk); #1 flag_clr = 0;
    #1 chk(irq_flag == 0, "R7", irq_flag, 0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule